// File: doc/BRIEF.md
# Single-Adder Eight-Function Arithmetic Unit

A combinational arithmetic unit that produces eight different results from one unsigned ripple adder. The adder always forms A + B + carry-in. The second operand is fixed to the data input `x_i`. The carry-in is wired straight to the lowest function-select bit. Only the first operand changes with the function: it can be all zeros, `y_i`, the bitwise complement of `y_i`, or all ones.

That operand is produced bit by bit from a minimal sum-of-products term of the two upper select bits and the matching bit of `y_i`. No multiplexer chooses among complete results. The result `g_o` is the sum modulo 2^W. The carry out of the top adder stage appears on `co_o`. The unit holds no state. Its outputs follow its inputs within the same evaluation.

Top module: `add_func_unit`

## Requirements
- R1: Select code 3'b000 gives `g_o` = `x_i` and `co_o` = 0.
- R2: Select code 3'b001 gives `g_o` = (`x_i` + 1) mod 16, with `co_o` = 1 only when `x_i` = 4'b1111.
- R3: Select code 3'b010 gives {`co_o`,`g_o`} = `x_i` + `y_i` as a 5-bit sum.
- R4: Select code 3'b011 gives {`co_o`,`g_o`} = `x_i` + `y_i` + 1 as a 5-bit sum.
- R5: Select code 3'b100 gives {`co_o`,`g_o`} = `x_i` + ~`y_i`, which is the ones'-complement difference.
- R6: Select code 3'b101 gives {`co_o`,`g_o`} = `x_i` + ~`y_i` + 1, which is `x_i` − `y_i` mod 16, with `co_o` = 1 exactly when `x_i` >= `y_i` (unsigned).
- R7: Select code 3'b110 gives `g_o` = (`x_i` − 1) mod 16, with `co_o` = 1 for every `x_i` except 4'b0000.
- R8: Select code 3'b111 gives `g_o` = `x_i` and `co_o` = 1, because `x_i` + 4'b1111 + 1 wraps back to `x_i`.
- R9: Select bit 0 acts only as the adder carry-in. For any `x_i` and `y_i`, the 5-bit value {`co_o`,`g_o`} under code 2k+1 equals the value under code 2k plus 1, modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 4 | Data operand, always the adder's fixed operand |
| y_i | input | 4 | Data operand, conditioned into the adder's other operand |
| sel_i | input | 3 | Function select: bits 2:1 choose the operand form, bit 0 is the carry-in |
| g_o | output | 4 | Result, adder sum modulo 16 |
| co_o | output | 1 | Carry out of the most significant adder stage |

## Verification
All 2048 combinations of `x_i`, `y_i` and `sel_i` are applied. Each result is compared with a reference in which every select code has its own arithmetic formula, so an error in any single function shows up on its own.

Operands of 0, 4'b1111 and `x_i` = `y_i` are part of the sweep. They separate the wrap and borrow cases: the carry of the increment, the carry of the decrement, and the carry of the two's-complement subtraction. The codes that differ only in bit 0 are also compared against each other. This shows whether bit 0 does anything beyond adding one through the carry-in.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    OP_PASS_LO = 3'b000,
    OP_INC     = 3'b001,
    OP_ADD     = 3'b010,
    OP_ADD_C   = 3'b011,
    OP_SUB_1C  = 3'b100,
    OP_SUB_2C  = 3'b101,
    OP_DEC     = 3'b110,
    OP_PASS_HI = 3'b111
  } afu_op_e;
endpackage

// File: rtl/afu_opnd_cond.sv
// Per-bit operand conditioning: a = s2 & ~y | s1 & y
module afu_opnd_cond #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] y_i,
  input  logic         form_hi_i,
  input  logic         form_lo_i,
  output logic [W-1:0] a_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign a_o[i] = (form_hi_i & ~y_i[i]) | (form_lo_i & y_i[i]);
  end
endmodule

// File: rtl/afu_full_add.sv
module afu_full_add (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/afu_ripple_add.sv
module afu_ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] carry;
  assign carry[0] = ci_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    afu_full_add u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (carry[i]),
      .s_o (s_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign co_o = carry[W];
endmodule

// File: rtl/add_func_unit.sv
module add_func_unit #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]                x_i,
  input  logic [W-1:0]                y_i,
  input  logic [afu_pkg::SEL_W-1:0]   sel_i,
  output logic [W-1:0]                g_o,
  output logic                        co_o
);
  logic [W-1:0] opnd_a;

  afu_opnd_cond #(.W(W)) u_cond (
    .y_i       (y_i),
    .form_hi_i (sel_i[2]),
    .form_lo_i (sel_i[1]),
    .a_o       (opnd_a)
  );

  afu_ripple_add #(.W(W)) u_add (
    .a_i  (opnd_a),
    .b_i  (x_i),
    .ci_i (sel_i[0]),
    .s_o  (g_o),
    .co_o (co_o)
  );
endmodule

// File: rtl/add_func_unit_chk.sv
module add_func_unit_chk #(
  parameter int unsigned W = 4
) (
  input logic [W-1:0]              x_i,
  input logic [W-1:0]              y_i,
  input logic [afu_pkg::SEL_W-1:0] sel_i,
  input logic [W-1:0]              g_o,
  input logic                      co_o
);
  import afu_pkg::*;

  logic [W:0] ext_x, ext_y, ext_yn, res;
  assign ext_x  = {1'b0, x_i};
  assign ext_y  = {1'b0, y_i};
  assign ext_yn = {1'b0, ~y_i};
  assign res    = {co_o, g_o};

  always_comb begin
    if (!$isunknown({x_i, y_i, sel_i, g_o, co_o})) begin
      if (sel_i == OP_PASS_LO)
        p_pass_lo_r1: assert (g_o == x_i && !co_o);
      if (sel_i == OP_INC)
        p_inc_r2: assert (g_o == W'(x_i + 1'b1) && co_o == (x_i == '1));
      if (sel_i == OP_ADD)
        p_add_r3: assert (res == ext_x + ext_y);
      if (sel_i == OP_ADD_C)
        p_add_c_r4: assert (res == ext_x + ext_y + (W+1)'(1));
      if (sel_i == OP_SUB_1C)
        p_sub_1c_r5: assert (res == ext_x + ext_yn);
      if (sel_i == OP_SUB_2C)
        p_sub_2c_r6: assert (g_o == W'(x_i - y_i) && co_o == (x_i >= y_i));
      if (sel_i == OP_DEC)
        p_dec_r7: assert (g_o == W'(x_i - 1'b1) && co_o == (x_i != '0));
      if (sel_i == OP_PASS_HI)
        p_pass_hi_r8: assert (g_o == x_i && co_o);
    end
  end
endmodule

bind add_func_unit add_func_unit_chk #(.W(W)) u_chk (
  .x_i   (x_i),
  .y_i   (y_i),
  .sel_i (sel_i),
  .g_o   (g_o),
  .co_o  (co_o)
);

// File: tb/add_func_unit_test.sv
`timescale 1ns/1ps
module add_func_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] x, y;
  logic [2:0] sel;
  logic [3:0] g;
  logic       co;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [4:0] seen [8][16][16];

  always #5 clk = ~clk;

  add_func_unit uut (
    .x_i   (x),
    .y_i   (y),
    .sel_i (sel),
    .g_o   (g),
    .co_o  (co)
  );

  function automatic int ref_val(int op, int xv, int yv);
    case (op)
      0: return xv;
      1: return xv + 1;
      2: return xv + yv;
      3: return xv + yv + 1;
      4: return xv + (15 - yv);
      5: return xv + (15 - yv) + 1;
      6: return xv + 15;
      default: return xv + 16;
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d sel=%0d)",
               req, act, exp, x, y, sel);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    x = '0; y = '0; sel = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle", {co, g}, 0);

    for (int op = 0; op < 8; op++) begin
      for (int xv = 0; xv < 16; xv++) begin
        for (int yv = 0; yv < 16; yv++) begin
          @(posedge clk);
          #1;
          x = 4'(xv); y = 4'(yv); sel = 3'(op);
          @(negedge clk);
          check(req_of(op), {co, g}, ref_val(op, xv, yv) % 32);
          seen[op][xv][yv] = {co, g};
        end
      end
    end

    // R9: bit 0 only adds one through the carry-in
    for (int k = 0; k < 4; k++)
      for (int xv = 0; xv < 16; xv++)
        for (int yv = 0; yv < 16; yv++)
          check("R9", seen[2*k+1][xv][yv],
                (int'(seen[2*k][xv][yv]) + 1) % 32);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule